// File: doc/BRIEF.md
# Instruction-Phase Serial Register Port

This block is a synchronous serial slave. It gives a host read and write access to a 32-entry file of byte-wide registers. Every transaction starts with one instruction byte. That byte is followed by one to four data bytes, which go to or come from consecutive register addresses. After the last data byte the port re-arms on its own, so the next eight rising clock edges form a new instruction. This happens whether or not chip select went high in between.

The serial clock, chip select and data input are oversampled in the system clock domain. Input bits are taken on the rising serial clock edge. Output bits change after the falling edge. Register 0 is the port's own configuration. It selects the bit order and chooses between a shared bidirectional data line and a separate output line. The register file can also be read in parallel by neighbouring logic.

Top module: `spi_regport`

## Requirements
- R1: The instruction byte is decoded as follows. Bit 7 set means read and bit 7 clear means write. Bits 6:5 hold the number of data bytes minus one. Bits 4:0 hold the address of the first register.
- R2: In a write, each completed data byte is stored in the current register, and the address then advances by one. The result is visible on the parallel read port (`rd_addr` selects the entry and `rd_data` returns it combinationally).
- R3: The address increment wraps from 31 to 0.
- R4: In a read, each data byte returns the current register contents. A new output bit appears only after a falling serial clock edge. The first data bit follows the falling edge that comes after the eighth instruction bit.
- R5: Once the counted bytes are done, the next eight rising edges are taken as a new instruction, even if chip select stays low.
- R6: When register 0 bit 0 is 1, every byte is shifted least significant bit first. When it is 0, every byte is shifted most significant bit first.
- R7: When register 0 bit 1 is 1 (two-pin mode), read data appears on `sdo` and `sdio_oe` stays low.
- R8: When register 0 bit 1 is 0 (single-pin mode), read data appears on `sdio_o`. In this mode `sdio_oe` is high only during the data phase of a read, and `sdo` stays low.
- R9: Raising chip select aborts the cycle. A partly shifted byte is never written, and the next cycle starts with a fresh instruction.
- R10: A change to register 0 takes effect at the first instruction bit of the next cycle. Later bytes in the cycle that wrote it keep the old settings.
- R11: After reset all registers read 0, the port is in single-pin, MSB-first mode, and `sdio_oe` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data input (the shared line in single-pin mode) |
| sdio_o | output | 1 | Serial data output onto the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo | output | 1 | Dedicated serial output in two-pin mode |
| rd_addr | input | 5 | Parallel read address |
| rd_data | output | 8 | Register contents at `rd_addr` |

## Verification
The main function is exercised with writes and reads of every length from one to four bytes. Some start near address 31, which separates a wrapping address counter from one that saturates or stops. The cycles are sent both as separate chip-select frames and back to back with chip select held low, which shows whether the port re-arms by counting bytes or only on chip select. Random traffic also rewrites the configuration register in the middle of multi-byte cycles, under all four combinations of bit order and pin mode. This separates a setting latched at the start of a cycle from one applied immediately. Aborts inside the instruction byte and inside a data byte check that partial bytes leave no trace.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int SYNC_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe,
  output logic       sdo,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int AW   = 5;
  localparam int NREG = 1 << AW;

  logic [SYNC_W:0]   sclk_sy;
  logic [SYNC_W-1:0] cs_sy, din_sy;
  logic [7:0]        regs [NREG];
  logic [7:0]        shreg;
  logic [2:0]        bitcnt;
  logic [1:0]        cnt;
  logic [AW-1:0]     addr;
  logic              in_data, is_rd, act_lsb, act_two, out_bit;

  wire rise   = sclk_sy[SYNC_W-1] & ~sclk_sy[SYNC_W];
  wire fall   = ~sclk_sy[SYNC_W-1] & sclk_sy[SYNC_W];
  wire cs_hi  = cs_sy[SYNC_W-1];
  wire din    = din_sy[SYNC_W-1];
  wire start  = !in_data && bitcnt == 3'd0;
  wire lsb_m  = start ? regs[0][0] : act_lsb;
  wire [7:0] nxt = lsb_m ? {din, shreg[7:1]} : {shreg[6:0], din};
  wire byte_done = rise && !cs_hi && bitcnt == 3'd7;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      din_sy  <= '0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_W-1:0], sclk};
      cs_sy   <= {cs_sy[SYNC_W-2:0], cs_n};
      din_sy  <= {din_sy[SYNC_W-2:0], sdio_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_data <= 1'b0;
      is_rd   <= 1'b0;
      cnt     <= '0;
      addr    <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      act_lsb <= 1'b0;
      act_two <= 1'b0;
      out_bit <= 1'b0;
    end else if (cs_hi) begin
      in_data <= 1'b0;
      bitcnt  <= '0;
    end else begin
      if (rise) begin
        if (start) begin
          act_lsb <= regs[0][0];
          act_two <= regs[0][1];
        end
        shreg  <= nxt;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (!in_data) begin
            in_data <= 1'b1;
            is_rd   <= nxt[7];
            cnt     <= nxt[6:5];
            addr    <= nxt[4:0];
          end else begin
            addr <= addr + 1'b1;
            cnt  <= cnt - 2'd1;
            if (cnt == 2'd0) in_data <= 1'b0;
          end
        end
      end
      if (fall && in_data && is_rd)
        out_bit <= regs[addr][act_lsb ? bitcnt : ~bitcnt];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (byte_done && in_data && !is_rd) begin
      regs[addr] <= nxt;
    end

  assign sdio_o  = out_bit;
  assign sdo     = act_two ? out_bit : 1'b0;
  assign sdio_oe = !act_two && in_data && is_rd && !cs_hi;
  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/spi_regport_sva.sv
module spi_regport_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       rise,
  input logic       fall,
  input logic       in_data,
  input logic       act_two,
  input logic       sdio_oe,
  input logic       sdo,
  input logic       out_bit,
  input logic [4:0] addr,
  input logic [2:0] bitcnt,
  input logic [1:0] cnt
);
  assert_two_pin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_two |-> !sdio_oe);

  assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_two |-> !sdo);

  assert_oe_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(rise));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (!in_data && bitcnt == 3'd0));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && rise && !cs_hi && bitcnt == 3'd7) |=> addr == $past(addr) + 5'd1);

  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && rise && !cs_hi && bitcnt == 3'd7 && addr == 5'd31) |=> addr == 5'd0);

  assert_launch_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(out_bit));

  assert_cycle_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && cnt == 2'd0 && rise && !cs_hi && bitcnt == 3'd7) |=> !in_data);
endmodule

bind spi_regport spi_regport_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .rise(rise), .fall(fall),
  .in_data(in_data), .act_two(act_two), .sdio_oe(sdio_oe), .sdo(sdo),
  .out_bit(out_bit), .addr(addr), .bitcnt(bitcnt), .cnt(cnt)
);

// File: tb/tb_spi_regport.sv
module tb_spi_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] model [32];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  spi_regport dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input bit two, output logic o, output logic oe);
    sdio_i = b;
    half();
    o  = two ? sdo : sdio_o;
    oe = sdio_oe;
    sclk = 1'b1;
    half();
    sclk = 1'b0;
  endtask

  task automatic scan_regs(input string req);
    int bad = 0, ba = 0;
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #1;
      if (rd_data !== model[a] && bad == 0) ba = a;
      if (rd_data !== model[a]) bad++;
    end
    rd_addr = 5'(ba);
    #1;
    chk(bad == 0, req, int'(rd_data), int'(model[ba]));
  endtask

  task automatic run_cycle(input bit rd, input int n, input logic [4:0] a,
                           input logic [31:0] wd, input bit end_cs, input string req);
    bit lsb, two;
    logic o, oe, oe_bad;
    logic [7:0] ins, got;
    logic [4:0] ad;
    if (cs_n) begin cs_n = 1'b0; half(); end
    lsb = model[0][0];
    two = model[0][1];
    ins = {rd, 2'(n - 1), a};
    oe_bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      shift_bit(ins[lsb ? i : 7 - i], two, o, oe);
      if (oe) oe_bad = 1'b1;
    end
    chk(!oe_bad, "R8 oe low during instruction", oe_bad, 0);
    for (int k = 0; k < n; k++) begin
      ad = a + 5'(k);
      oe_bad = 1'b0;
      for (int i = 0; i < 8; i++) begin
        shift_bit(wd[8*k + (lsb ? i : 7 - i)], two, o, oe);
        got[lsb ? i : 7 - i] = o;
        if (rd && oe !== !two) oe_bad = 1'b1;
        if (!rd && oe) oe_bad = 1'b1;
      end
      if (rd) begin
        chk(got === model[ad], "R4/R6 read byte", int'(got), int'(model[ad]));
        chk(!oe_bad, two ? "R7 oe in two-pin read" : "R8 oe in single-pin read", oe_bad, 0);
      end else begin
        model[ad] = wd[8*k +: 8];
        chk(!oe_bad, "R8 oe low during write", oe_bad, 0);
      end
    end
    if (end_cs) begin
      half();
      cs_n = 1'b1;
      half(); half();
    end
    scan_regs(req);
  endtask

  task automatic partial(input logic [7:0] ins, input int nbits, input string req);
    logic o, oe;
    cs_n = 1'b0; half();
    for (int i = 0; i < nbits; i++) shift_bit(model[0][0] ? ins[i % 8] : ins[7 - (i % 8)], 1'b0, o, oe);
    half();
    cs_n = 1'b1;
    half(); half();
    scan_regs(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdio_oe && !sdo, "R11 outputs after reset", {sdio_oe, sdo}, 0);
    scan_regs("R11 registers zero after reset");

    run_cycle(0, 1, 5'd7, 32'h0000_00c3, 1, "R1/R2 single write");
    run_cycle(0, 4, 5'd10, 32'h1122_3344, 1, "R2 four-byte write");
    run_cycle(1, 4, 5'd10, 0, 1, "R4 four-byte read");
    run_cycle(0, 3, 5'd30, 32'h00ab_cdef, 1, "R3 wrap write");
    run_cycle(1, 3, 5'd30, 0, 1, "R3 wrap read");
    run_cycle(0, 2, 5'd4, 32'h0000_5a96, 0, "R5 back-to-back first");
    run_cycle(1, 2, 5'd4, 0, 0, "R5 back-to-back second");
    run_cycle(0, 1, 5'd20, 32'h0000_0077, 1, "R5 back-to-back third");
    run_cycle(0, 2, 5'd0, 32'h0000_a501, 1, "R10 cfg write keeps order in same cycle");
    run_cycle(1, 2, 5'd1, 0, 1, "R6 LSB-first read");
    run_cycle(0, 2, 5'd2, 32'h0000_1e2d, 1, "R6 LSB-first write");
    run_cycle(0, 1, 5'd0, 32'h0000_0002, 1, "R7 enter two-pin");
    run_cycle(1, 4, 5'd1, 0, 1, "R7 two-pin read");
    partial(8'h45, 3, "R9 abort in instruction");
    partial(8'h25, 12, "R9 abort in data byte");
    run_cycle(0, 1, 5'd5, 32'h0000_00e1, 1, "R9 full cycle after abort");
    run_cycle(0, 1, 5'd0, 32'h0000_0000, 1, "R10 back to defaults");

    for (int it = 0; it < 40; it++) begin
      bit rd, ec;
      int n;
      logic [4:0] a;
      rd = 1'($urandom % 2);
      n  = 1 + int'($urandom % 4);
      a  = 5'($urandom % 32);
      ec = ($urandom % 4) != 0;
      run_cycle(rd, n, a, $urandom, ec, "R2/R4/R6/R10 random");
    end
    if (!cs_n) begin half(); cs_n = 1'b1; half(); half(); end
    run_cycle(1, 4, 5'd28, 0, 1, "R3/R4 final wrap read");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule